// File: doc/BRIEF.md
# Interrupt Cascade Identification Unit

This unit is the part of an interrupt controller that lets one master controller and up to eight slave controllers share a single processor interrupt line. One master with eight slaves gives up to 64 request inputs. A configuration bit selects the role. In master mode the unit drives a 3-bit cascade ID bus. In slave mode it listens to that bus.

During an interrupt acknowledge sequence, the master captures the request index chosen by the priority resolver on the first acknowledge pulse. If a slave hangs off that input, the master drives the index onto the cascade bus until the last pulse ends. A slave compares the bus with its stored 3-bit ID. It raises its vector enable only on the later pulses of the sequence, and only while the ID matches. If the winning master input has no slave, the master enables its own vector and leaves the bus idle.

The bus is modelled as a separate input, output and output enable, so the pad ring can build the shared lines. Every pin is a plain control or status signal. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_cascade_unit`

## Requirements
- R1: While reset is asserted and after reset, cas_oe, cas_out and vec_en are 0. The stored configuration is slave role, ID 0, empty slave map and two-pulse sequence.
- R2: A cfg_load pulse is taken only while the pulse count is zero and ack is low. It stores role (cfg_master, 1 = master), sequence length, ID and slave map. A cfg_load during a sequence is ignored, so the next sequence still uses the old configuration.
- R3: In master mode, the first ack rise samples win_idx. If bit win_idx of the slave map is 1, then from the next clock cas_oe is 1 and cas_out equals win_idx. Both hold through the gaps between pulses. They return to 0 on the clock after the last pulse falls.
- R4: In master mode with bit win_idx of the map 0, cas_oe and cas_out stay 0 for the whole sequence. vec_en is 1 while ack is high on pulses two to last.
- R5: In slave mode cas_oe is always 0. vec_en is 1 exactly while ack is high, the pulse count is at least 2 and cas_in equals the stored ID.
- R6: vec_en is never 1 during the first pulse of a sequence.
- R7: A sequence has two pulses when cfg_long_seq is 0 and three when it is 1. After the last pulse falls, the next ack rise starts a new sequence as its first pulse.
- R8: win_idx is used only at the first pulse. Changes to it later in the sequence do not change cas_out.
- R9: vec_en falls in the same cycle that ack falls, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load strobe for the configuration fields |
| cfg_master | input | 1 | Role: 1 master, 0 slave |
| cfg_long_seq | input | 1 | 1 selects a three-pulse sequence, 0 a two-pulse sequence |
| cfg_id | input | 3 | ID of this unit when it is a slave |
| cfg_map | input | 8 | Bit i set means a slave sits on master input i |
| ack | input | 1 | Acknowledge pulse, active high |
| win_idx | input | 3 | Winning request index from the priority resolver |
| cas_in | input | 3 | Cascade bus as seen at the pins |
| cas_out | output | 3 | Cascade ID driven by a master, 0 when released |
| cas_oe | output | 1 | Output enable for the cascade pins |
| vec_en | output | 1 | Enable for this unit's vector on the data bus |

## Verification
The assertions assume a few things about the inputs. Each acknowledge pulse is high for at least one clock and separated from the next by at least one low clock. cas_in stays steady while a pulse is high. ack only rises when the unit is idle or mid-sequence, never as a glitch inside a clock. The stimulus applies every input on the falling clock edge. It holds each pulse and gap for whole cycles and presents cas_in and win_idx before the first pulse. Only the directed tests change win_idx or pulse cfg_load inside a sequence, and they do so on purpose to show that these inputs are ignored there.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int CAS_W  = 3;
  localparam int NUM_IN = 1 << CAS_W;
  localparam int PCNT_W = 2;

  typedef struct packed {
    logic              master;
    logic              long_seq;
    logic [CAS_W-1:0]  id;
    logic [NUM_IN-1:0] map;
  } cas_cfg_t;
endpackage

// File: rtl/cas_cfg_reg.sv
module cas_cfg_reg
  import cas_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     idle,
  input  cas_cfg_t cfg_d,
  output cas_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfg_q <= '0;
    else if (load && idle) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
  import cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              long_seq,
  output logic [PCNT_W-1:0] pulse_num,
  output logic              start,
  output logic              done,
  output logic              idle
);
  localparam logic [PCNT_W-1:0] LAST_SHORT = PCNT_W'(2);
  localparam logic [PCNT_W-1:0] LAST_LONG  = PCNT_W'(3);

  logic ack_q;
  logic rise, fall;
  logic [PCNT_W-1:0] last;

  assign last  = long_seq ? LAST_LONG : LAST_SHORT;
  assign rise  = ack & ~ack_q;
  assign fall  = ~ack & ack_q;
  assign start = rise & (pulse_num == '0);
  assign done  = fall & (pulse_num == last);
  assign idle  = (pulse_num == '0) & ~ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      pulse_num <= '0;
    end else begin
      ack_q <= ack;
      if (done)
        pulse_num <= '0;
      else if (rise && pulse_num != LAST_LONG)
        pulse_num <= pulse_num + 1'b1;
    end
  end
endmodule

// File: rtl/cas_master_drv.sv
module cas_master_drv
  import cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  logic              is_master,
  input  logic [NUM_IN-1:0] slave_map,
  input  logic [CAS_W-1:0]  win_idx,
  output logic [CAS_W-1:0]  cas_out,
  output logic              cas_oe,
  output logic              own_vec
);
  logic [CAS_W-1:0] sel_q;
  logic             drive_q;
  logic             has_slave;

  assign has_slave = slave_map[win_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      drive_q <= 1'b0;
      own_vec <= 1'b0;
    end else if (start) begin
      sel_q   <= win_idx;
      drive_q <= is_master & has_slave;
      own_vec <= is_master & ~has_slave;
    end else if (done) begin
      sel_q   <= '0;
      drive_q <= 1'b0;
      own_vec <= 1'b0;
    end
  end

  assign cas_oe  = drive_q;
  assign cas_out = drive_q ? sel_q : '0;
endmodule

// File: rtl/cas_slave_cmp.sv
module cas_slave_cmp
  import cas_pkg::*;
(
  input  logic [CAS_W-1:0] cas_in,
  input  logic [CAS_W-1:0] my_id,
  output logic             match
);
  logic [CAS_W-1:0] eq;
  for (genvar b = 0; b < CAS_W; b++) begin : g_bit
    assign eq[b] = ~(cas_in[b] ^ my_id[b]);
  end
  assign match = &eq;
endmodule

// File: rtl/irq_cascade_unit.sv
module irq_cascade_unit
  import cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_master,
  input  logic              cfg_long_seq,
  input  logic [CAS_W-1:0]  cfg_id,
  input  logic [NUM_IN-1:0] cfg_map,
  input  logic              ack,
  input  logic [CAS_W-1:0]  win_idx,
  input  logic [CAS_W-1:0]  cas_in,
  output logic [CAS_W-1:0]  cas_out,
  output logic              cas_oe,
  output logic              vec_en
);
  localparam logic [PCNT_W-1:0] FIRST_VEC_PULSE = PCNT_W'(2);

  cas_cfg_t          cfg_d, cfg_q;
  logic [PCNT_W-1:0] pulse_num;
  logic              seq_start, seq_done, seq_idle;
  logic              own_vec, id_match, late_pulse;

  assign cfg_d = '{master: cfg_master, long_seq: cfg_long_seq,
                   id: cfg_id, map: cfg_map};

  cas_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .idle(seq_idle),
    .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  cas_ack_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ack(ack), .long_seq(cfg_q.long_seq),
    .pulse_num(pulse_num), .start(seq_start), .done(seq_done), .idle(seq_idle)
  );

  cas_master_drv u_mst (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .done(seq_done),
    .is_master(cfg_q.master), .slave_map(cfg_q.map), .win_idx(win_idx),
    .cas_out(cas_out), .cas_oe(cas_oe), .own_vec(own_vec)
  );

  cas_slave_cmp u_cmp (
    .cas_in(cas_in), .my_id(cfg_q.id), .match(id_match)
  );

  assign late_pulse = ack & (pulse_num >= FIRST_VEC_PULSE);
  assign vec_en = late_pulse & (cfg_q.master ? own_vec : id_match);
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk
  import cas_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [CAS_W-1:0]  cas_in,
  input logic [CAS_W-1:0]  cas_out,
  input logic              cas_oe,
  input logic              vec_en,
  input logic [PCNT_W-1:0] pulse_num,
  input cas_cfg_t          cfg_q
);
  // R5: a slave never drives the cascade pins
  a_r5_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> cfg_q.master);
  // R5: a slave enables its vector only on an ID match
  a_r5_vec_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en && !cfg_q.master) |-> (cas_in == cfg_q.id));
  // R3: released pins carry zero
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_oe |-> (cas_out == '0));
  // R6: no vector during the first pulse
  a_r6_no_first_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_num < PCNT_W'(2)) |-> !vec_en);
  // R9: vector enable needs ack high
  a_r9_vec_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> !vec_en);
  // R8: the driven ID holds for the whole sequence
  a_r8_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_oe && $past(cas_oe)) |-> $stable(cas_out));
  // R2: configuration is frozen once a sequence is under way
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_num != '0) |=> $stable(cfg_q));
endmodule

bind irq_cascade_unit cas_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .cas_in(cas_in), .cas_out(cas_out),
  .cas_oe(cas_oe), .vec_en(vec_en), .pulse_num(pulse_num), .cfg_q(cfg_q)
);

// File: tb/irq_cascade_unit_tb.sv
module irq_cascade_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {master, long, id[3], map[8], win[3], cas[3], exp_oe, exp_out[3], exp_vec}
  localparam logic [23:0] TBL [NV] = '{
    {1'b1, 1'b0, 3'd0, 8'h04, 3'd2, 3'd0, 1'b1, 3'd2, 1'b0},
    {1'b1, 1'b1, 3'd0, 8'h04, 3'd3, 3'd0, 1'b0, 3'd0, 1'b1},
    {1'b1, 1'b1, 3'd0, 8'hFF, 3'd7, 3'd0, 1'b1, 3'd7, 1'b0},
    {1'b0, 1'b0, 3'd5, 8'h00, 3'd0, 3'd5, 1'b0, 3'd0, 1'b1},
    {1'b0, 1'b1, 3'd5, 8'h00, 3'd0, 3'd4, 1'b0, 3'd0, 1'b0},
    {1'b0, 1'b1, 3'd0, 8'h00, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1},
    {1'b1, 1'b0, 3'd0, 8'h80, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1},
    {1'b0, 1'b0, 3'd7, 8'h00, 3'd3, 3'd7, 1'b0, 3'd0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_master = 1'b0, cfg_long_seq = 1'b0, ack = 1'b0;
  logic [2:0] cfg_id = '0, win_idx = '0, cas_in = '0;
  logic [7:0] cfg_map = '0;
  logic [2:0] cas_out;
  logic cas_oe, vec_en;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_unit u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic m, input logic l, input logic [2:0] id, input logic [7:0] map);
    cfg_master = m; cfg_long_seq = l; cfg_id = id; cfg_map = map; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic ack_rise(); ack = 1'b1; @(negedge clk); endtask
  task automatic ack_fall(); ack = 1'b0; @(negedge clk); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", {7'd0, cas_oe}, 8'd0);
    chk("R1 out in reset", {5'd0, cas_out}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vec after reset", {7'd0, vec_en}, 8'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [23:0] t;
      t = TBL[i];
      load_cfg(t[23], t[22], t[21:19], t[18:11]);
      win_idx = t[10:8]; cas_in = t[7:5];
      ack_rise();
      chk("R3 R4 oe pulse1", {7'd0, cas_oe}, {7'd0, t[4]});
      chk("R3 out pulse1", {5'd0, cas_out}, {5'd0, t[3:1]});
      chk("R6 vec pulse1", {7'd0, vec_en}, 8'd0);
      ack_fall();
      chk("R3 oe in gap", {7'd0, cas_oe}, {7'd0, t[4]});
      ack_rise();
      chk("R4 R5 vec pulse2", {7'd0, vec_en}, {7'd0, t[0]});
      ack_fall();
      if (t[22]) begin
        ack_rise();
        chk("R7 vec pulse3", {7'd0, vec_en}, {7'd0, t[0]});
        ack_fall();
      end
      chk("R3 R7 oe after last", {7'd0, cas_oe}, 8'd0);
      chk("R3 out after last", {5'd0, cas_out}, 8'd0);
    end

    // R9: vec_en drops in the same cycle ack falls
    load_cfg(1'b0, 1'b0, 3'd2, 8'h00);
    cas_in = 3'd2;
    ack_rise(); ack_fall(); ack_rise();
    chk("R9 vec before fall", {7'd0, vec_en}, 8'd1);
    ack = 1'b0; #1;
    chk("R9 vec same cycle", {7'd0, vec_en}, 8'd0);
    @(negedge clk);

    // R7: short mode, third pulse starts a fresh sequence; R8 win_idx ignored late
    load_cfg(1'b1, 1'b0, 3'd0, 8'h22);
    win_idx = 3'd1;
    ack_rise(); win_idx = 3'd5; ack_fall();
    chk("R8 out after win change", {5'd0, cas_out}, 8'd1);
    ack_rise(); ack_fall();
    ack_rise();
    chk("R7 new seq out", {5'd0, cas_out}, 8'd5);
    chk("R7 new seq vec", {7'd0, vec_en}, 8'd0);
    ack_fall(); ack_rise(); ack_fall();

    // R2: load during a sequence is ignored
    win_idx = 3'd1;
    ack_rise(); ack_fall();
    load_cfg(1'b0, 1'b0, 3'd1, 8'h00);
    cas_in = 3'd1;
    ack_rise();
    chk("R2 vec keeps master cfg", {7'd0, vec_en}, 8'd0);
    chk("R2 oe keeps master cfg", {7'd0, cas_oe}, 8'd1);
    ack_fall();
    ack_rise();
    chk("R2 next seq still master", {7'd0, cas_oe}, 8'd1);
    ack_fall(); ack_rise(); ack_fall();

    // R5: slave never drives even with a map loaded
    load_cfg(1'b0, 1'b0, 3'd1, 8'hFF);
    ack_rise();
    chk("R5 slave oe", {7'd0, cas_oe}, 8'd0);
    ack_fall(); ack_rise();
    chk("R5 slave vec match", {7'd0, vec_en}, 8'd1);
    ack_fall();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule